// File: doc/BRIEF.md
# Strobed handshake port with interrupt

This block is one 8-bit data port that moves bytes under a two-wire handshake. In input mode, an external device pulls a strobe low to hand the port a byte. The port latches the pins, raises its buffer-full flag, and raises an interrupt when the strobe returns high. The host then reads the byte, and the read strobe clears both flags. In output mode, a host write places a byte on the pins and pulls the active-low buffer-full flag low. The external device answers with an acknowledge pulse: its falling edge frees the buffer, and its rising edge raises the interrupt.

All four strobes are asynchronous: the external strobe, the acknowledge, and the internal read and write strobes. Each passes through a synchroniser, and the flags react to the edges detected in the system clock domain. The interrupt enable is not an ordinary register. It is one port C bit, written through the single-bit set/reset command that the neighbouring control decoder hands in. The port interrupt reaches the host line only when two further enables are set: a per-port bit in the first interrupt control byte and a global bit in the second.

A level input picks the mode. Any change of mode returns every handshake flag to its idle state.

Top module: `hsp_strobed_port`

## Requirements
- R1: After reset, the flags are idle: `ibf`=0, `obf_n`=1, `intr`=0. The interrupt enable is 0, both interrupt control enables are 0, `host_irq`=0, and `pin_out` and `host_rdata` are 0.
- R2: In input mode (`mode_out`=0), a falling edge of `stb_n` sets `ibf`. For as long as the synchronised strobe is low, `pin_in` is copied into the latch shown on `host_rdata`. The latch keeps the last copied value once the strobe is high, and it does not change in output mode.
- R3: In input mode, a rising edge of `stb_n` sets `intr` when the interrupt enable and `ibf` are both 1.
- R4: In input mode, a falling edge of `rd_n` clears `intr`, and a rising edge of `rd_n` clears `ibf`.
- R5: In output mode (`mode_out`=1), a rising edge of `wr_n` copies `host_wdata` onto `pin_out` and drives `obf_n` low. A falling edge of `wr_n` clears `intr`. `pin_out` does not change in input mode.
- R6: In output mode, a falling edge of `ack_n` drives `obf_n` high. A rising edge of `ack_n` sets `intr` when the interrupt enable is 1.
- R7: A set/reset command (`bsr_valid`=1) whose `bsr_bit` equals INTE_BIT (default 4) writes `bsr_set` into the interrupt enable. Clearing the enable also clears `intr`. A command for any other bit leaves the enable unchanged. `intr` is never 1 while the enable is 0.
- R8: `host_irq` = `intr` AND port enable AND global enable. A pulse on `icr1_wr` loads the port enable from `icr_wdata` bit PORT_IDX (0 for the first port, 1 for the second). A pulse on `icr2_wr` loads the global enable from `icr_wdata` bit 2.
- R9: A strobe edge on a pin acts on the flags on the (SYNC_STAGES+1)-th rising clock edge after the pin changes (the third edge for the default of 2).
- R10: `status` = {flag, enable, `intr`}, from bit 2 down to bit 0. The flag is `ibf` in input mode and `obf_n` (active low) in output mode.
- R11: On the clock edge after `mode_out` changes, `ibf`, `obf_n` and `intr` return to 0, 1 and 0. `pin_oe` equals `mode_out`.
- R12: Strobes that belong to the other mode have no effect. `stb_n` and `rd_n` are ignored in output mode, and `ack_n` and `wr_n` are ignored in input mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_out | input | 1 | 0 = strobed input, 1 = strobed output |
| stb_n | input | 1 | External input strobe, active low, asynchronous |
| ack_n | input | 1 | External output acknowledge, active low, asynchronous |
| rd_n | input | 1 | Host read strobe, active low, asynchronous |
| wr_n | input | 1 | Host write strobe, active low, asynchronous |
| pin_in | input | 8 | Port pins as inputs |
| pin_out | output | 8 | Port pins as outputs |
| pin_oe | output | 1 | Pin output enable |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Latched input byte |
| bsr_valid | input | 1 | Single-bit set/reset command strobe |
| bsr_bit | input | 3 | Port C bit addressed by the command |
| bsr_set | input | 1 | 1 = set, 0 = reset |
| icr1_wr | input | 1 | Write pulse for the per-port enable byte |
| icr2_wr | input | 1 | Write pulse for the global enable byte |
| icr_wdata | input | 8 | Data for interrupt control writes, reserved bits 0 |
| ibf | output | 1 | Input buffer full |
| obf_n | output | 1 | Output buffer full, active low |
| intr | output | 1 | Port interrupt request |
| status | output | 3 | {flag, enable, intr} |
| host_irq | output | 1 | Gated interrupt to the host |

## Verification
The hardest situation to reach is the interplay of the interrupt with its two paths for clearing. One path is a read or write strobe. The other is a set/reset command that drops the enable while a request is pending. Both can occur only after a full handshake has raised the request. The stimulus therefore completes each transfer first. It then clears the enable with the request high, and it toggles the global enable with the request still pending. A model of the synchroniser latency in the bench is compared with every output on every clock, so each edge is checked in the cycle it should act, and not only at the end of a pulse.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

   typedef struct packed {
      logic lvl;
      logic fall;
      logic rise;
   } strobe_t;

   typedef enum logic {
      MODE_IN  = 1'b0,
      MODE_OUT = 1'b1
   } hs_mode_e;

   localparam int ICR_GLOBAL_BIT = 2;
   localparam int NUM_STROBES    = 4;
   localparam int IDX_STB        = 0;
   localparam int IDX_ACK        = 1;
   localparam int IDX_RD         = 2;
   localparam int IDX_WR         = 3;

endpackage

// File: rtl/hsp_sync_edge.sv
module hsp_sync_edge #(
   parameter int   STAGES = 2,
   parameter logic IDLE   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw,
   output hsp_pkg::strobe_t ev
);
   logic [STAGES-1:0] chain;
   logic              prev;

   if (STAGES < 2) begin : g_bad_stages
      $error("hsp_sync_edge: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{IDLE}};
         prev  <= IDLE;
      end else begin
         chain <= {chain[STAGES-2:0], raw};
         prev  <= chain[STAGES-1];
      end
   end

   assign ev.lvl  = chain[STAGES-1];
   assign ev.fall = prev & ~chain[STAGES-1];
   assign ev.rise = ~prev & chain[STAGES-1];
endmodule

// File: rtl/hsp_flags.sv
module hsp_flags #(
   parameter int W        = 8,
   parameter int PC_W     = 8,
   parameter int INTE_BIT = 4,
   localparam int SEL_W   = $clog2(PC_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  hsp_pkg::hs_mode_e  mode,
   input  hsp_pkg::strobe_t   stb,
   input  hsp_pkg::strobe_t   ack,
   input  hsp_pkg::strobe_t   rd,
   input  hsp_pkg::strobe_t   wr,
   input  logic [W-1:0]       pin_in,
   input  logic [W-1:0]       host_wdata,
   input  logic               bsr_valid,
   input  logic [SEL_W-1:0]   bsr_bit,
   input  logic               bsr_set,
   output logic               ibf,
   output logic               obf_n,
   output logic               intr,
   output logic               inte,
   output logic [W-1:0]       in_latch,
   output logic [W-1:0]       out_reg
);
   import hsp_pkg::*;

   hs_mode_e mode_q;
   logic     inte_hit;

   if (INTE_BIT < 0 || INTE_BIT >= PC_W) begin : g_bad_inte
      $error("hsp_flags: INTE_BIT outside port C");
   end

   assign inte_hit = bsr_valid && (bsr_bit == SEL_W'(INTE_BIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_IN;
         ibf      <= 1'b0;
         obf_n    <= 1'b1;
         intr     <= 1'b0;
         inte     <= 1'b0;
         in_latch <= '0;
         out_reg  <= '0;
      end else begin
         mode_q <= mode;
         if (mode != mode_q) begin
            ibf   <= 1'b0;
            obf_n <= 1'b1;
            intr  <= 1'b0;
         end else if (mode == MODE_IN) begin
            if (!stb.lvl) in_latch <= pin_in;
            if (rd.rise)  ibf <= 1'b0;
            if (stb.fall) ibf <= 1'b1;
            if (rd.fall)  intr <= 1'b0;
            if (stb.rise && inte && ibf) intr <= 1'b1;
         end else begin
            if (wr.rise) begin
               obf_n   <= 1'b0;
               out_reg <= host_wdata;
            end
            if (ack.fall) obf_n <= 1'b1;
            if (wr.fall)  intr <= 1'b0;
            if (ack.rise && inte) intr <= 1'b1;
         end
         if (inte_hit) begin
            inte <= bsr_set;
            if (!bsr_set) intr <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/hsp_irq_gate.sv
module hsp_irq_gate #(
   parameter int ICR_W    = 8,
   parameter int PORT_IDX = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             icr1_wr,
   input  logic             icr2_wr,
   input  logic [ICR_W-1:0] icr_wdata,
   input  logic             intr,
   output logic             host_irq
);
   logic port_en;
   logic glob_en;

   if (PORT_IDX < 0 || PORT_IDX > 1) begin : g_bad_port
      $error("hsp_irq_gate: PORT_IDX must be 0 or 1");
   end
   if (ICR_W <= hsp_pkg::ICR_GLOBAL_BIT) begin : g_bad_icr
      $error("hsp_irq_gate: ICR_W too narrow");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_en <= 1'b0;
         glob_en <= 1'b0;
      end else begin
         if (icr1_wr) port_en <= icr_wdata[PORT_IDX];
         if (icr2_wr) glob_en <= icr_wdata[hsp_pkg::ICR_GLOBAL_BIT];
      end
   end

   assign host_irq = intr & port_en & glob_en;
endmodule

// File: rtl/hsp_strobed_port.sv
module hsp_strobed_port #(
   parameter int W           = 8,
   parameter int SYNC_STAGES = 2,
   parameter int INTE_BIT    = 4,
   parameter int PORT_IDX    = 0,
   parameter int ICR_W       = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         mode_out,
   input  logic         stb_n,
   input  logic         ack_n,
   input  logic         rd_n,
   input  logic         wr_n,
   input  logic [W-1:0] pin_in,
   output logic [W-1:0] pin_out,
   output logic         pin_oe,
   input  logic [W-1:0] host_wdata,
   output logic [W-1:0] host_rdata,
   input  logic         bsr_valid,
   input  logic [2:0]   bsr_bit,
   input  logic         bsr_set,
   input  logic         icr1_wr,
   input  logic         icr2_wr,
   input  logic [ICR_W-1:0] icr_wdata,
   output logic         ibf,
   output logic         obf_n,
   output logic         intr,
   output logic [2:0]   status,
   output logic         host_irq
);
   import hsp_pkg::*;

   localparam int PC_W = 8;

   logic [NUM_STROBES-1:0] raw_vec;
   strobe_t                ev [NUM_STROBES];
   logic                   inte;
   hs_mode_e               mode;

   assign raw_vec[IDX_STB] = stb_n;
   assign raw_vec[IDX_ACK] = ack_n;
   assign raw_vec[IDX_RD]  = rd_n;
   assign raw_vec[IDX_WR]  = wr_n;
   assign mode = mode_out ? MODE_OUT : MODE_IN;

   for (genvar g = 0; g < NUM_STROBES; g++) begin : g_sync
      hsp_sync_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .raw   (raw_vec[g]),
         .ev    (ev[g])
      );
   end

   hsp_flags #(.W(W), .PC_W(PC_W), .INTE_BIT(INTE_BIT)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .stb        (ev[IDX_STB]),
      .ack        (ev[IDX_ACK]),
      .rd         (ev[IDX_RD]),
      .wr         (ev[IDX_WR]),
      .pin_in     (pin_in),
      .host_wdata (host_wdata),
      .bsr_valid  (bsr_valid),
      .bsr_bit    (bsr_bit),
      .bsr_set    (bsr_set),
      .ibf        (ibf),
      .obf_n      (obf_n),
      .intr       (intr),
      .inte       (inte),
      .in_latch   (host_rdata),
      .out_reg    (pin_out)
   );

   hsp_irq_gate #(.ICR_W(ICR_W), .PORT_IDX(PORT_IDX)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .icr1_wr   (icr1_wr),
      .icr2_wr   (icr2_wr),
      .icr_wdata (icr_wdata),
      .intr      (intr),
      .host_irq  (host_irq)
   );

   assign pin_oe = mode_out;
   assign status = {(mode_out ? obf_n : ibf), inte, intr};
endmodule

// File: rtl/hsp_strobed_port_chk.sv
module hsp_strobed_port_chk #(
   parameter int W     = 8,
   parameter int ICR_W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         mode_out,
   input logic [W-1:0] pin_out,
   input logic [W-1:0] host_rdata,
   input logic         ibf,
   input logic         obf_n,
   input logic         intr,
   input logic [2:0]   status
);
   assert_in_obf_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_out && $past(!mode_out)) |-> obf_n);

   assert_out_ibf_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_out && $past(mode_out)) |-> !ibf);

   assert_intr_needs_inte_R7: assert property (@(posedge clk) disable iff (!rst_n)
      intr |-> status[1]);

   assert_ibf_rise_in_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ibf) |-> !mode_out);

   assert_obf_fall_out_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(obf_n) |-> mode_out);

   assert_pins_hold_in_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_out && $past(!mode_out)) |-> $stable(pin_out));

   assert_latch_hold_out_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_out && $past(mode_out)) |-> $stable(host_rdata));
endmodule

bind hsp_strobed_port hsp_strobed_port_chk #(.W(W), .ICR_W(ICR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_out   (mode_out),
   .pin_out    (pin_out),
   .host_rdata (host_rdata),
   .ibf        (ibf),
   .obf_n      (obf_n),
   .intr       (intr),
   .status     (status)
);

// File: tb/hsp_strobed_port_tb.sv
`timescale 1ns/1ps
module hsp_strobed_port_tb;
   localparam int S = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_out = 1'b0;
   logic       stb_n = 1'b1, ack_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [7:0] pin_in = 8'h00, host_wdata = 8'h00, icr_wdata = 8'h00;
   logic       bsr_valid = 1'b0, bsr_set = 1'b0;
   logic [2:0] bsr_bit = 3'd0;
   logic       icr1_wr = 1'b0, icr2_wr = 1'b0;
   logic [7:0] pin_out, host_rdata;
   logic       pin_oe, ibf, obf_n, intr, host_irq;
   logic [2:0] status;

   int    checks = 0;
   int    errors = 0;
   string phase = "R1 reset";

   always #2 clk = ~clk;

   hsp_strobed_port #(.SYNC_STAGES(S)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_out(mode_out),
      .stb_n(stb_n), .ack_n(ack_n), .rd_n(rd_n), .wr_n(wr_n),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .bsr_valid(bsr_valid), .bsr_bit(bsr_bit), .bsr_set(bsr_set),
      .icr1_wr(icr1_wr), .icr2_wr(icr2_wr), .icr_wdata(icr_wdata),
      .ibf(ibf), .obf_n(obf_n), .intr(intr), .status(status),
      .host_irq(host_irq)
   );

   // Reference model: strobe pin values are delayed S cycles, then edges act one edge later (R9)
   logic [3:0] m_hist [S];
   logic [3:0] m_prev;
   logic       m_ibf, m_obf_n, m_intr, m_inte, m_pen, m_gen, m_mode;
   logic [7:0] m_latch, m_out;

   always @(posedge clk) begin
      logic [3:0] lvl, fl, rs;
      if (!rst_n) begin
         for (int i = 0; i < S; i++) m_hist[i] = 4'hF;
         m_prev = 4'hF;
         m_ibf = 0; m_obf_n = 1; m_intr = 0; m_inte = 0;
         m_pen = 0; m_gen = 0; m_mode = 0; m_latch = 0; m_out = 0;
      end else begin
         lvl = m_hist[S-1];
         fl  = m_prev & ~lvl;
         rs  = ~m_prev & lvl;
         if (mode_out != m_mode) begin
            m_ibf = 0; m_obf_n = 1; m_intr = 0;
         end else if (!mode_out) begin
            if (!lvl[0]) m_latch = pin_in;
            if (rs[2]) m_ibf = 0;
            if (fl[0]) m_ibf = 1;
            if (fl[2]) m_intr = 0;
            if (rs[0] && m_inte && m_ibf) m_intr = 1;
         end else begin
            if (rs[3]) begin m_obf_n = 0; m_out = host_wdata; end
            if (fl[1]) m_obf_n = 1;
            if (fl[3]) m_intr = 0;
            if (rs[1] && m_inte) m_intr = 1;
         end
         if (bsr_valid && bsr_bit == 3'd4) begin
            m_inte = bsr_set;
            if (!bsr_set) m_intr = 0;
         end
         if (icr1_wr) m_pen = icr_wdata[0];
         if (icr2_wr) m_gen = icr_wdata[2];
         m_mode = mode_out;
         m_prev = m_hist[S-1];
         for (int j = S-1; j > 0; j--) m_hist[j] = m_hist[j-1];
         m_hist[0] = {wr_n, rd_n, ack_n, stb_n};
      end
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s [%s]: actual %0h expected %0h", tag, phase, act, exp);
      end
   endtask

   // Every-clock comparison, sampled 1 ns after the rising edge
   always @(posedge clk) begin
      #1;
      chk("R2 ibf", {7'd0, ibf}, {7'd0, m_ibf});
      chk("R5 obf_n", {7'd0, obf_n}, {7'd0, m_obf_n});
      chk("R3 intr", {7'd0, intr}, {7'd0, m_intr});
      chk("R8 host_irq", {7'd0, host_irq}, {7'd0, m_intr & m_pen & m_gen});
      chk("R2 host_rdata", host_rdata, m_latch);
      chk("R5 pin_out", pin_out, m_out);
      chk("R10 status", {5'd0, status},
          {5'd0, (mode_out ? m_obf_n : m_ibf), m_inte, m_intr});
      chk("R11 pin_oe", {7'd0, pin_oe}, {7'd0, mode_out});
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bsr(input logic [2:0] b, input logic v);
      bsr_bit = b; bsr_set = v; bsr_valid = 1'b1;
      tick(1);
      bsr_valid = 1'b0;
   endtask

   task automatic icr(input logic which2, input logic [7:0] d);
      icr_wdata = d;
      if (which2) icr2_wr = 1'b1; else icr1_wr = 1'b1;
      tick(1);
      icr1_wr = 1'b0; icr2_wr = 1'b0; icr_wdata = 8'h00;
   endtask

   task automatic in_xfer(input logic [7:0] d);
      pin_in = d; tick(2);
      stb_n = 1'b0; tick(5);
      stb_n = 1'b1; tick(8);
      pin_in = ~d; tick(4);
   endtask

   task automatic pulse(ref logic sig, input int len);
      sig = 1'b0; tick(len);
      sig = 1'b1; tick(6);
   endtask

   initial begin
      tick(3);
      // R1: reset state, taken with reset still applied
      chk("R1 ibf", {7'd0, ibf}, 8'd0);
      chk("R1 obf_n", {7'd0, obf_n}, 8'd1);
      chk("R1 status", {5'd0, status}, 8'd0);
      rst_n = 1'b1; tick(2);

      phase = "R8 enables";
      icr(1'b0, 8'h01); icr(1'b1, 8'h04);
      phase = "R7 enable on";
      bsr(3'd4, 1'b1);
      chk("R7 status enable", {7'd0, status[1]}, 8'd1);

      // R9: ibf rises on the third edge after stb_n falls
      phase = "R9 latency";
      pin_in = 8'hA5; tick(2);
      stb_n = 1'b0;
      @(posedge clk); @(posedge clk); #1;
      chk("R9 ibf before", {7'd0, ibf}, 8'd0);
      @(posedge clk); #1;
      chk("R9 ibf after", {7'd0, ibf}, 8'd1);
      tick(3); stb_n = 1'b1; tick(8); pin_in = 8'h5A; tick(4);
      phase = "R3 intr on strobe rise";
      chk("R3 intr set", {7'd0, intr}, 8'd1);
      chk("R2 latch A5", host_rdata, 8'hA5);
      chk("R8 host_irq on", {7'd0, host_irq}, 8'd1);

      phase = "R8 global off";
      icr(1'b1, 8'h00); tick(1);
      chk("R8 host_irq gated", {7'd0, host_irq}, 8'd0);
      icr(1'b1, 8'h04);

      phase = "R4 read clears";
      pulse(rd_n, 4);
      chk("R4 ibf cleared", {7'd0, ibf}, 8'd0);
      chk("R4 intr cleared", {7'd0, intr}, 8'd0);

      phase = "R12 ack/wr ignored in input";
      pulse(ack_n, 3); pulse(wr_n, 3);
      chk("R12 obf_n idle", {7'd0, obf_n}, 8'd1);

      phase = "R7 other bit ignored";
      bsr(3'd3, 1'b0); bsr(3'd2, 1'b0);
      in_xfer(8'h3C);
      chk("R7 intr kept enable", {7'd0, intr}, 8'd1);
      phase = "R7 clear drops intr";
      bsr(3'd4, 1'b0); tick(1);
      chk("R7 intr dropped", {7'd0, intr}, 8'd0);
      chk("R2 latch 3C", host_rdata, 8'h3C);
      pulse(rd_n, 3);

      phase = "R3 disabled";
      in_xfer(8'hC3);
      chk("R3 no intr", {7'd0, intr}, 8'd0);

      phase = "R11 mode to output";
      mode_out = 1'b1; tick(2);
      chk("R11 ibf reset", {7'd0, ibf}, 8'd0);
      bsr(3'd4, 1'b1);

      phase = "R5 write";
      host_wdata = 8'h96;
      pulse(wr_n, 4);
      chk("R5 pin_out", pin_out, 8'h96);
      chk("R5 obf_n low", {7'd0, obf_n}, 8'd0);
      chk("R10 status flag obf_n", {7'd0, status[2]}, 8'd0);

      phase = "R12 stb/rd ignored in output";
      pin_in = 8'hFF; pulse(stb_n, 4); pulse(rd_n, 3);
      chk("R12 latch kept", host_rdata, 8'hC3);

      phase = "R6 acknowledge";
      pulse(ack_n, 4);
      chk("R6 obf_n high", {7'd0, obf_n}, 8'd1);
      chk("R6 intr set", {7'd0, intr}, 8'd1);

      phase = "R5 next write clears intr";
      host_wdata = 8'h01;
      wr_n = 1'b0; tick(4);
      chk("R5 intr cleared", {7'd0, intr}, 8'd0);
      wr_n = 1'b1; tick(6);
      pulse(ack_n, 3);

      phase = "R11 mode back to input";
      mode_out = 1'b0; tick(2);
      chk("R11 obf_n reset", {7'd0, obf_n}, 8'd1);
      chk("R11 intr reset", {7'd0, intr}, 8'd0);
      tick(4);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule